// File: doc/BRIEF.md
# Bus Master Takeover Sequencer

This block hands permanent ownership of the system bus to an add-in processor after power-up. It watches the system reset and the address strobe of the on-board CPU. Once system reset has ended, it raises a bus request towards the on-board arbiter and waits for the grant. When the grant has arrived and the bus cycle in flight has finished, it raises an ownership signal that enables the add-in processor's bus drivers.

Every bus-side input is asynchronous to the sequencer clock, so each one passes through a two-stage synchroniser before the state machine uses it. A build-time parameter selects whether the sequencer waits for the first address strobe after reset before it requests the bus. The wait is a cautious choice and is not strictly required. Once ownership is taken it is kept. Only a new system reset releases it, and that reset also aborts a takeover that is only partly done.

Top module: `bus_takeover_seq`

## Requirements
- R1: While the local reset `rst` is high, and on the first cycle after it, `bus_req` and `bus_own` are both low.
- R2: While system reset is asserted, both outputs stay low whatever the strobe, grant and acknowledge inputs do.
- R3: With `WAIT_FIRST_CYCLE=1`, `bus_req` stays low after system reset ends until an address strobe has been seen.
- R4: With `WAIT_FIRST_CYCLE=0`, `bus_req` rises once system reset ends, without any address strobe.
- R5: `bus_own` rises only after a grant has been seen while `bus_req` is high and both address strobe and data acknowledge are low. While either of those is high, `bus_req` stays high and `bus_own` stays low.
- R6: `bus_req` falls in the same cycle that `bus_own` rises, and the two are never high together.
- R7: Once `bus_own` is high it stays high, whatever grant, strobe and acknowledge do, until system reset is asserted.
- R8: A system reset asserted at any point of the sequence drops both outputs within three clock edges.
- R9: Each asynchronous input passes two synchroniser flops, and the outputs are registered. A change on an input therefore shows on the outputs at the third rising clock edge after it, and not earlier.
- R10: If the grant is withdrawn before ownership has been taken, the sequencer goes back to requesting: `bus_req` stays high and `bus_own` stays low until a grant is seen again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Local synchronous reset, active high |
| sys_reset_a | input | 1 | System reset, asynchronous, active high |
| strobe_a | input | 1 | Address strobe of the current bus cycle, asynchronous, active high |
| grant_a | input | 1 | Bus grant from the on-board arbiter, asynchronous, active high |
| ack_a | input | 1 | Data acknowledge of the current bus cycle, asynchronous, active high |
| bus_req | output | 1 | Bus request to the on-board arbiter, registered |
| bus_own | output | 1 | Ownership signal that enables the add-in drivers, registered |

## Verification
The bench builds two copies of the block from the same stimulus. One has `WAIT_FIRST_CYCLE=1` and the other has `WAIT_FIRST_CYCLE=0`, both with two synchroniser stages. Comparing them in the same cycles shows the request held back by the missing first strobe in one copy and issued at once in the other. With the default stage count the three-edge latency can be checked on an exact edge. That also lets the bench hold the block in its grant-seen state while strobe or acknowledge is still high, before it releases the bus cycle.

// File: rtl/takeover_pkg.sv
package takeover_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_WAIT_CYC = 3'd1,
    ST_REQ      = 3'd2,
    ST_SETTLE   = 3'd3,
    ST_OWN      = 3'd4
  } tko_state_t;

  localparam int unsigned IN_RST    = 0;
  localparam int unsigned IN_STROBE = 1;
  localparam int unsigned IN_GRANT  = 2;
  localparam int unsigned IN_ACK    = 3;
  localparam int unsigned IN_COUNT  = 4;

endpackage

// File: rtl/sig_sync_bank.sv
module sig_sync_bank #(
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(STAGES); i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d_async;
      for (int i = 1; i < int'(STAGES); i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q_sync = pipe[STAGES-1];

endmodule

// File: rtl/takeover_fsm.sv
module takeover_fsm
  import takeover_pkg::*;
#(
  parameter bit WAIT_FIRST_CYCLE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic rst_s,
  input  logic strobe_s,
  input  logic grant_s,
  input  logic ack_s,
  output logic bus_req,
  output logic bus_own
);

  tko_state_t st, nxt;

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE:     nxt = WAIT_FIRST_CYCLE ? ST_WAIT_CYC : ST_REQ;
      ST_WAIT_CYC: if (strobe_s) nxt = ST_REQ;
      ST_REQ:      if (grant_s) nxt = ST_SETTLE;
      ST_SETTLE: begin
        if (!grant_s)                  nxt = ST_REQ;
        else if (!strobe_s && !ack_s)  nxt = ST_OWN;
      end
      ST_OWN:      nxt = ST_OWN;
      default:     nxt = ST_IDLE;
    endcase
    if (rst_s) nxt = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      bus_req <= 1'b0;
      bus_own <= 1'b0;
    end else begin
      st      <= nxt;
      bus_req <= (nxt == ST_REQ) || (nxt == ST_SETTLE);
      bus_own <= (nxt == ST_OWN);
    end
  end

  // R6: request and ownership never overlap
  p_req_own_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(bus_req && bus_own));

  // R5: ownership only after grant with an idle bus
  p_own_idle_bus_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_own) |-> ($past(grant_s) && !$past(strobe_s) && !$past(ack_s)
                        && $past(bus_req)));

  // R7: ownership held until system reset
  p_own_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_own && !rst_s) |=> bus_own);

  // R8: system reset releases both outputs
  p_reset_idle_r8: assert property (@(posedge clk) disable iff (rst)
    rst_s |=> (!bus_req && !bus_own));

  generate
    if (WAIT_FIRST_CYCLE) begin : g_wait_chk
      // R3: request rises only from a seen strobe
      p_wait_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> $past(strobe_s));
    end
  endgenerate

endmodule

// File: rtl/bus_takeover_seq.sv
module bus_takeover_seq
  import takeover_pkg::*;
#(
  parameter bit          WAIT_FIRST_CYCLE = 1'b1,
  parameter int unsigned SYNC_STAGES      = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sys_reset_a,
  input  logic strobe_a,
  input  logic grant_a,
  input  logic ack_a,
  output logic bus_req,
  output logic bus_own
);

  localparam logic [IN_COUNT-1:0] SYNC_RST = IN_COUNT'(1) << IN_RST;

  logic [IN_COUNT-1:0] raw, synced;

  always_comb begin
    raw            = '0;
    raw[IN_RST]    = sys_reset_a;
    raw[IN_STROBE] = strobe_a;
    raw[IN_GRANT]  = grant_a;
    raw[IN_ACK]    = ack_a;
  end

  sig_sync_bank #(
    .WIDTH  (IN_COUNT),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d_async(raw),
    .q_sync (synced)
  );

  takeover_fsm #(
    .WAIT_FIRST_CYCLE(WAIT_FIRST_CYCLE)
  ) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .rst_s   (synced[IN_RST]),
    .strobe_s(synced[IN_STROBE]),
    .grant_s (synced[IN_GRANT]),
    .ack_s   (synced[IN_ACK]),
    .bus_req (bus_req),
    .bus_own (bus_own)
  );

endmodule

// File: tb/test_bus_takeover_seq.sv
module test_bus_takeover_seq;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sys_reset_a = 1'b1;
  logic strobe_a = 1'b0;
  logic grant_a = 1'b0;
  logic ack_a = 1'b0;
  logic req_w, own_w, req_n, own_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_takeover_seq #(.WAIT_FIRST_CYCLE(1'b1), .SYNC_STAGES(2)) i_bus_takeover_seq (
    .clk(clk), .rst(rst), .sys_reset_a(sys_reset_a), .strobe_a(strobe_a),
    .grant_a(grant_a), .ack_a(ack_a), .bus_req(req_w), .bus_own(own_w));

  bus_takeover_seq #(.WAIT_FIRST_CYCLE(1'b0), .SYNC_STAGES(2)) i_bus_takeover_seq_nowait (
    .clk(clk), .rst(rst), .sys_reset_a(sys_reset_a), .strobe_a(strobe_a),
    .grant_a(grant_a), .ack_a(ack_a), .bus_req(req_n), .bus_own(own_n));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic t_reset_state;
    step(3);
    chk(req_w, 1'b0, "R1 req during rst");
    chk(own_w, 1'b0, "R1 own during rst");
    rst = 1'b0;
    step(1);
    chk(req_w, 1'b0, "R1 req after rst");
    chk(own_n, 1'b0, "R1 own after rst");
  endtask

  task automatic t_hold_in_reset;
    strobe_a = 1'b1; grant_a = 1'b1; ack_a = 1'b1;
    step(6);
    chk(req_w, 1'b0, "R2 req wait copy");
    chk(own_w, 1'b0, "R2 own wait copy");
    chk(req_n, 1'b0, "R2 req nowait copy");
    chk(own_n, 1'b0, "R2 own nowait copy");
    strobe_a = 1'b0; grant_a = 1'b0; ack_a = 1'b0;
    step(4);
  endtask

  task automatic t_first_cycle;
    sys_reset_a = 1'b0;
    step(2);
    chk(req_n, 1'b0, "R9 req not before third edge");
    step(1);
    chk(req_n, 1'b1, "R4 R9 req at third edge");
    chk(req_w, 1'b0, "R3 no req without strobe");
    step(6);
    chk(req_w, 1'b0, "R3 still no req");
    strobe_a = 1'b1;
    step(3);
    chk(req_w, 1'b1, "R3 req after strobe");
  endtask

  task automatic t_grant_busy;
    grant_a = 1'b1;
    step(6);
    chk(req_w, 1'b1, "R5 req held while strobe high");
    chk(own_w, 1'b0, "R5 no own while strobe high");
    strobe_a = 1'b0; ack_a = 1'b1;
    step(6);
    chk(req_w, 1'b1, "R5 req held while ack high");
    chk(own_w, 1'b0, "R5 no own while ack high");
    grant_a = 1'b0;
    step(6);
    chk(req_w, 1'b1, "R10 req after grant withdrawn");
    chk(own_w, 1'b0, "R10 no own after grant withdrawn");
    ack_a = 1'b0;
    step(6);
    chk(own_w, 1'b0, "R10 no own without fresh grant");
    grant_a = 1'b1;
    step(5);
    chk(own_w, 1'b1, "R5 own after grant and idle bus");
    chk(req_w, 1'b0, "R6 req dropped with own");
    chk(own_n, 1'b1, "R5 own nowait copy");
  endtask

  task automatic t_hold_own;
    grant_a = 1'b0; strobe_a = 1'b1; ack_a = 1'b1;
    step(7);
    chk(own_w, 1'b1, "R7 own kept");
    chk(req_w, 1'b0, "R7 req stays low");
    strobe_a = 1'b0; ack_a = 1'b0;
  endtask

  task automatic t_mid_reset;
    sys_reset_a = 1'b1;
    step(3);
    chk(own_w, 1'b0, "R8 own dropped");
    chk(req_w, 1'b0, "R8 req low");
    sys_reset_a = 1'b0;
    step(5);
    strobe_a = 1'b1;
    step(4);
    chk(req_w, 1'b1, "R3 req after new strobe");
    sys_reset_a = 1'b1;
    step(3);
    chk(req_w, 1'b0, "R8 req dropped mid request");
    sys_reset_a = 1'b0; grant_a = 1'b1;
    step(8);
    chk(own_w, 1'b0, "R5 no own while strobe high again");
    strobe_a = 1'b0;
    step(4);
    chk(own_w, 1'b1, "R5 own after fresh sequence");
  endtask

  initial begin
    t_reset_state();
    t_hold_in_reset();
    t_first_cycle();
    t_grant_busy();
    t_hold_own();
    t_mid_reset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule